// File: doc/BRIEF.md
# Stream Beat and Packet Index Tracker

This block sits beside a streaming interface that uses a valid/ready handshake with a start-of-frame flag and an end-of-line flag. It observes the bus only and drives no part of it. It keeps two registered counters. The beat index gives the position of the current beat inside a line. The packet index counts the lines that have ended since the frame started. A one-cycle pulse marks each accepted beat that closes a line.

The next counter values are formed by combinational logic from the registered values and the bus flags. A single clocked stage then captures them, so every output is a plain register. A cycle with no accepted transfer returns both counters to zero. Indices therefore describe an unbroken run of accepted beats. Both counter widths are parameters, and both counters wrap around at their maximum value.

Top module: `stream_beat_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, `beat_idx`, `pkt_idx` and `pkt_end` are all 0 after that edge.
- R2: At an edge where `s_valid` and `s_ready` are not both high, both counters become 0 and `pkt_end` becomes 0.
- R3: At an edge with an accepted beat (`s_valid` and `s_ready` both 1) and `s_user` = 1, both counters become 0, whatever the value of `s_last`.
- R4: At an edge with an accepted beat, `s_user` = 0 and `s_last` = 0, `beat_idx` increases by one and `pkt_idx` keeps its value.
- R5: At an edge with an accepted beat, `s_user` = 0 and `s_last` = 1, `beat_idx` becomes 0 and `pkt_idx` increases by one.
- R6: `pkt_end` is 1 for exactly the one cycle that follows an edge with an accepted beat carrying `s_last` = 1, whatever the value of `s_user`. At all other times it is 0.
- R7: `beat_idx` wraps from 2^BEAT_W-1 to 0 on an increment and never saturates.
- R8: `pkt_idx` wraps from 2^PKT_W-1 to 0 on an increment and never saturates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Observed transfer-valid flag |
| s_ready | input | 1 | Observed transfer-ready flag |
| s_user | input | 1 | Observed start-of-frame flag |
| s_last | input | 1 | Observed end-of-line flag |
| beat_idx | output | BEAT_W | Beat position within the current line |
| pkt_idx | output | PKT_W | Number of lines ended since the frame started |
| pkt_end | output | 1 | One-cycle pulse after an accepted end-of-line beat |

## Verification
The tests use several kinds of beat stream:
- Unbroken runs of plain beats show that the increment path works.
- Beats with `s_last` set check that the line end resets the beat index while the packet index advances.
- Beats with the start flag set, alone and together with `s_last`, check that the start flag takes priority for the counters but still lets the end pulse through.
- Stalls with valid low or ready low show that a half handshake clears both counters and is not treated as a hold.
- Long runs with small counter widths reach both wrap points.

// File: rtl/stream_beat_tracker.sv
module stream_beat_tracker #(
  parameter int BEAT_W = 8,
  parameter int PKT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic              s_user,
  input  logic              s_last,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [PKT_W-1:0]  pkt_idx,
  output logic              pkt_end
);

  logic              accept;
  logic [BEAT_W-1:0] beat_nx;
  logic [PKT_W-1:0]  pkt_nx;

  assign accept = s_valid & s_ready;

  always_comb begin
    beat_nx = '0;
    pkt_nx  = '0;
    if (accept && !s_user) begin
      if (s_last) begin
        pkt_nx = pkt_idx + 1'b1;
      end else begin
        beat_nx = beat_idx + 1'b1;
        pkt_nx  = pkt_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_idx <= '0;
      pkt_idx  <= '0;
      pkt_end  <= 1'b0;
    end else begin
      beat_idx <= beat_nx;
      pkt_idx  <= pkt_nx;
      pkt_end  <= accept & s_last;
    end
  end

endmodule

// File: rtl/stream_beat_tracker_chk.sv
module stream_beat_tracker_chk #(
  parameter int BEAT_W = 8,
  parameter int PKT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_user,
  input logic              s_last,
  input logic [BEAT_W-1:0] beat_idx,
  input logic [PKT_W-1:0]  pkt_idx,
  input logic              pkt_end
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (beat_idx == '0 && pkt_idx == '0 && !pkt_end));

  assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> (beat_idx == '0 && pkt_idx == '0 && !pkt_end));

  assert_user_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && s_user) |=> (beat_idx == '0 && pkt_idx == '0));

  assert_beat_step_R4: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !s_user && !s_last) |=>
      (beat_idx == BEAT_W'($past(beat_idx) + 1'b1) && $stable(pkt_idx)));

  assert_line_end_R5: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !s_user && s_last) |=>
      (beat_idx == '0 && pkt_idx == PKT_W'($past(pkt_idx) + 1'b1)));

  assert_end_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && s_last) |=> pkt_end);

  assert_end_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready && s_last) |=> !pkt_end);

endmodule

bind stream_beat_tracker stream_beat_tracker_chk #(.BEAT_W(BEAT_W), .PKT_W(PKT_W)) chk_i (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .s_user(s_user), .s_last(s_last), .beat_idx(beat_idx),
  .pkt_idx(pkt_idx), .pkt_end(pkt_end)
);

// File: tb/stream_beat_tracker_tb_top.sv
module stream_beat_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_ready = 1'b0, s_user = 1'b0, s_last = 1'b0;
  logic [BW-1:0] beat_idx;
  logic [PW-1:0] pkt_idx;
  logic pkt_end;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int eb = 0, ep = 0, ee = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_beat_tracker #(.BEAT_W(BW), .PKT_W(PW)) dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_user(s_user), .s_last(s_last), .beat_idx(beat_idx),
    .pkt_idx(pkt_idx), .pkt_end(pkt_end)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " beat"}, int'(beat_idx), eb);
    chk({req, " pkt"}, int'(pkt_idx), ep);
    chk({req, " end"}, int'(pkt_end), ee);
  endtask

  task automatic step(bit v, bit r, bit u, bit l);
    @(negedge clk);
    s_valid = v; s_ready = r; s_user = u; s_last = l;
    if (rst) begin eb = 0; ep = 0; ee = 0; end
    else if (!(v && r)) begin eb = 0; ep = 0; ee = 0; end
    else begin
      ee = l;
      if (u) begin eb = 0; ep = 0; end
      else if (l) begin eb = 0; ep = (ep + 1) % (1 << PW); end
      else eb = (eb + 1) % (1 << BW);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(1, 1, 0, 1);
    chk_all("R1");
    rst = 1'b0;
  endtask

  task automatic t_run;
    for (int i = 0; i < 5; i++) begin step(1, 1, 0, 0); chk_all("R4"); end
    chk("R4 beat five", int'(beat_idx), 5);
  endtask

  task automatic t_line_end;
    step(1, 1, 0, 0); step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    chk_all("R5");
    chk("R6 pulse", int'(pkt_end), 1);
    step(1, 1, 0, 0);
    chk_all("R6 single");
    chk("R4 pkt held", int'(pkt_idx), 1);
  endtask

  task automatic t_user;
    step(1, 1, 0, 0); step(1, 1, 0, 1); step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    chk_all("R3");
    step(1, 1, 0, 0); step(1, 1, 0, 1);
    step(1, 1, 1, 1);
    chk_all("R3 with last");
    chk("R6 pulse with user", int'(pkt_end), 1);
  endtask

  task automatic t_stall;
    step(1, 1, 0, 0); step(1, 1, 0, 1); step(1, 1, 0, 0);
    step(1, 0, 0, 1);
    chk_all("R2 ready low");
    chk("R2 no pulse", int'(pkt_end), 0);
    step(1, 1, 0, 0); step(1, 1, 0, 1);
    step(0, 1, 0, 0);
    chk_all("R2 valid low");
  endtask

  task automatic t_beat_wrap;
    step(0, 0, 0, 0);
    for (int i = 0; i < (1 << BW) - 1; i++) step(1, 1, 0, 0);
    chk("R7 at max", int'(beat_idx), (1 << BW) - 1);
    step(1, 1, 0, 0);
    chk_all("R7 wrap");
    chk("R7 zero", int'(beat_idx), 0);
  endtask

  task automatic t_pkt_wrap;
    step(0, 0, 0, 0);
    for (int i = 0; i < (1 << PW) - 1; i++) begin step(1, 1, 0, 0); step(1, 1, 0, 1); end
    chk("R8 at max", int'(pkt_idx), (1 << PW) - 1);
    step(1, 1, 0, 1);
    chk_all("R8 wrap");
    chk("R8 zero", int'(pkt_idx), 0);
  endtask

  initial begin
    t_reset();
    t_run();
    t_line_end();
    t_user();
    t_stall();
    t_beat_wrap();
    t_pkt_wrap();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule